// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock for an I2C master. A power-of-two prescaler divides the system clock into ticks. Two 5-bit counts then set how many ticks SCL is held low and how many ticks it is released high. Each phase also gets a fixed overhead that stands in for the input synchronizer and the glitch filter. The overhead is 4 ticks when the prescaler is bypassed and 3 ticks otherwise. Software writes the prescale select and the two counts through a small byte-wide register port. Register bits outside the defined fields always read back as 1.

While `run` is high, the generator alternates between low and high phases. When a low phase ends, the generator releases the line. It then waits until its filtered copy of the bus clock reads high before it counts the high phase, so a slave that holds SCL low stretches the cycle. The bit engine gets two single-cycle strobes:
- one at the start of every low phase, when SDA may change;
- one at the middle of every high phase, when SDA is sampled.

When `run` falls, the phase in progress runs to the end of its high part and the line then stays released.

Top module: `scl_clock_gen`

## Requirements
- R1: Register reads are combinational. Address 0 returns the prescale select in bits [6:4], with every other bit 1. Addresses 1 and 2 return the low count and the high count in bits [4:0], with bits [7:5] reading 1. Address 3 reads 0xFF. After reset, the select is 0 and both counts are 31.
- R2: A write to address 0 updates the select only when bit 3 of the written byte is 1. Otherwise the select keeps its value.
- R3: Writing a count value of 0 stores 1. Written bits [7:5] of a count register are ignored.
- R4: Each low phase drives SCL low for exactly (L + K) × 2^S clock cycles, where L is the low count, S is the select, and K is 4 when S = 0 and 3 otherwise.
- R5: Without stretching, SCL stays released for 5 + (H + K) × 2^S cycles between low phases, where H is the high count: synchronizer and filter latency, then the counted high phase.
- R6: If the bus is held low for D extra cycles after the release, the released interval grows by exactly D cycles. The high count starts only once the filtered bus reads high.
- R7: `strobe_change` is high for exactly one cycle: the first cycle of each low phase. It is never high at any other time.
- R8: `strobe_sample` pulses exactly once per high phase. Counting the cycle after the release as 1, it falls on cycle 6 + D + floor((H + K)/2) × 2^S, and it never occurs while SCL is driven low.
- R9: After reset and while `run` is low in idle, SCL is released and no strobe is issued. When `run` is seen high in idle, a low phase starts on the next clock edge.
- R10: If `run` falls during a phase, that low phase and the following high phase complete, including the sample strobe, and no further low phase begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| run | input | 1 | Request continuous SCL cycles |
| scl_in | input | 1 | Raw level seen on the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| strobe_change | output | 1 | One-cycle pulse at the start of a low phase |
| strobe_sample | output | 1 | One-cycle pulse at mid high phase |

## Verification
Register reads settle in the same cycle the address is applied, and a write shows on readback from the next cycle on. The first low phase begins one edge after `run` is presented. The bench therefore checks the drive output at the very next falling edge. Low widths are counted in cycles from that point. Released widths and the sample strobe position are counted from the first falling edge after the release. The expected values include the fixed five-cycle latency through the two synchronizer stages, the filter and the state register, plus any stretch the bench's slave model adds. All sampling happens on falling edges, half a cycle away from the edges where the design moves.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_RISE = 2'd2,
      PH_HIGH = 2'd3
   } scl_phase_e;

   localparam int unsigned REG_PRESC = 0;
   localparam int unsigned REG_LOW   = 1;
   localparam int unsigned REG_HIGH  = 2;

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
   import scl_gen_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 2,
   parameter int CNT_W   = 5,
   parameter int SEL_W   = 3,
   parameter int SEL_LSB = 4,
   parameter int KEY_BIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [SEL_W-1:0]  sel,
   output logic [CNT_W-1:0]  low_cnt,
   output logic [CNT_W-1:0]  high_cnt
);

   localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(REG_PRESC);
   localparam logic [ADDR_W-1:0] A_LOW   = ADDR_W'(REG_LOW);
   localparam logic [ADDR_W-1:0] A_HIGH  = ADDR_W'(REG_HIGH);
   localparam logic [CNT_W-1:0]  CNT_MIN = CNT_W'(1);
   localparam logic [CNT_W-1:0]  CNT_RST = '1;

   if (SEL_LSB + SEL_W > DATA_W) begin : g_bad_sel
      $error("select field does not fit the data width");
   end
   if (KEY_BIT >= SEL_LSB) begin : g_bad_key
      $error("key bit must sit below the select field");
   end
   if (CNT_W >= DATA_W) begin : g_bad_cnt
      $error("count field must leave reserved bits");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("three registers need two address bits");
   end

   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] low_q, high_q;

   function automatic logic [CNT_W-1:0] floor_cnt(input logic [CNT_W-1:0] v);
      return (v == '0) ? CNT_MIN : v;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         low_q  <= CNT_RST;
         high_q <= CNT_RST;
      end else if (wr_en) begin
         case (addr)
            A_PRESC: if (wdata[KEY_BIT]) sel_q <= wdata[SEL_LSB +: SEL_W];
            A_LOW:   low_q  <= floor_cnt(wdata[CNT_W-1:0]);
            A_HIGH:  high_q <= floor_cnt(wdata[CNT_W-1:0]);
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '1;
      case (addr)
         A_PRESC: rdata[SEL_LSB +: SEL_W] = sel_q;
         A_LOW:   rdata[CNT_W-1:0] = low_q;
         A_HIGH:  rdata[CNT_W-1:0] = high_q;
         default: ;
      endcase
   end

   assign sel      = sel_q;
   assign low_cnt  = low_q;
   assign high_cnt = high_q;

   // R2: a write without the key leaves the select untouched
   a_r2_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_PRESC && !wdata[KEY_BIT]) |=> $stable(sel_q));

   // R3: stored counts never reach zero
   a_r3_count_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (low_q != '0) && (high_q != '0));

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   localparam int PW = (1 << SEL_W) - 1;

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("prescale select width must be 1 to 4");
   end

   logic [PW-1:0] pcnt;
   logic [PW-1:0] limit;
   logic [PW:0]   one_sh;

   always_comb begin
      one_sh = (PW+1)'(1) << sel;
      limit  = PW'(one_sh - (PW+1)'(1));
   end

   assign tick = en && (pcnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pcnt <= '0;
      else if (!en || tick)   pcnt <= '0;
      else                    pcnt <= pcnt + PW'(1);
   end

   // R4: every counted phase starts from a fresh prescaler period
   a_r4_fresh_period: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> (pcnt == '0));

endmodule

// File: rtl/scl_in_filter.sv
module scl_in_filter #(
   parameter int SYNC_STAGES = 2,
   parameter bit FILTER_EN   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   output logic scl_seen
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchronizer stages are required");
   end

   logic [SYNC_STAGES-1:0] chain;
   logic                   sync_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[SYNC_STAGES-2:0], scl_in};
   end

   assign sync_out = chain[SYNC_STAGES-1];

   if (FILTER_EN) begin : g_filter
      logic s_prev, filt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_prev <= 1'b1;
            filt_q <= 1'b1;
         end else begin
            s_prev <= sync_out;
            if (sync_out == s_prev) filt_q <= s_prev;
         end
      end

      assign scl_seen = filt_q;

      // R6: the filtered level only moves after two agreeing samples
      a_r6_filter_agree: assert property (@(posedge clk) disable iff (!rst_n)
         (filt_q != $past(filt_q)) |-> ($past(sync_out) == filt_q && $past(s_prev) == filt_q));
   end else begin : g_direct
      assign scl_seen = sync_out;
   end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
   import scl_gen_pkg::*;
#(
   parameter int CNT_W      = 5,
   parameter int SEL_W      = 3,
   parameter int OVH_DIRECT = 4,
   parameter int OVH_DIV    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             scl_seen,
   input  logic [SEL_W-1:0] sel,
   input  logic [CNT_W-1:0] low_cnt,
   input  logic [CNT_W-1:0] high_cnt,
   output logic             count_en,
   output logic             drive_low,
   output logic             strobe_change,
   output logic             strobe_sample
);

   localparam int PH_W = CNT_W + 1;

   if (OVH_DIRECT < 2 || OVH_DIV < 2) begin : g_bad_ovh_min
      $error("phase overhead must be at least two ticks");
   end
   if (OVH_DIRECT > (1 << CNT_W) || OVH_DIV > (1 << CNT_W)) begin : g_bad_ovh_max
      $error("phase overhead does not fit the phase counter");
   end

   scl_phase_e       st;
   logic [PH_W-1:0]  cnt;
   logic [PH_W-1:0]  ovh, len_low, len_high, half_high;
   logic             end_low, end_high, mid_high;

   always_comb begin
      ovh       = (sel == '0) ? PH_W'(OVH_DIRECT) : PH_W'(OVH_DIV);
      len_low   = PH_W'(low_cnt) + ovh;
      len_high  = PH_W'(high_cnt) + ovh;
      half_high = len_high >> 1;
      end_low   = tick && (cnt == len_low - PH_W'(1));
      end_high  = tick && (cnt == len_high - PH_W'(1));
      mid_high  = tick && (cnt == half_high - PH_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st            <= PH_IDLE;
         cnt           <= '0;
         strobe_change <= 1'b0;
         strobe_sample <= 1'b0;
      end else begin
         strobe_change <= 1'b0;
         strobe_sample <= 1'b0;
         case (st)
            PH_IDLE: begin
               cnt <= '0;
               if (run) begin
                  st            <= PH_LOW;
                  strobe_change <= 1'b1;
               end
            end
            PH_LOW: begin
               if (end_low) begin
                  st  <= PH_RISE;
                  cnt <= '0;
               end else if (tick) begin
                  cnt <= cnt + PH_W'(1);
               end
            end
            PH_RISE: begin
               cnt <= '0;
               if (scl_seen) st <= PH_HIGH;
            end
            PH_HIGH: begin
               if (mid_high) strobe_sample <= 1'b1;
               if (end_high) begin
                  cnt <= '0;
                  if (run) begin
                     st            <= PH_LOW;
                     strobe_change <= 1'b1;
                  end else begin
                     st <= PH_IDLE;
                  end
               end else if (tick) begin
                  cnt <= cnt + PH_W'(1);
               end
            end
            default: st <= PH_IDLE;
         endcase
      end
   end

   assign drive_low = (st == PH_LOW);
   assign count_en  = (st == PH_LOW) || (st == PH_HIGH);

   // R7: the change strobe only appears while the line is pulled low
   a_r7_change_in_low: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_change |-> drive_low);

   // R7: the change strobe lasts a single cycle
   a_r7_change_single: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_change |=> !strobe_change);

   // R8: sampling happens only on a released line
   a_r8_sample_released: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_sample |-> !drive_low);

   // R8: the two strobes never coincide
   a_r8_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({strobe_change, strobe_sample}));

   // R6: the high count starts only after the filtered bus reads high
   a_r6_high_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_HIGH && $past(st) == PH_RISE) |-> $past(scl_seen));

   // R4: a low phase ends only on its final tick
   a_r4_low_complete: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_RISE && $past(st) == PH_LOW) |->
         ($past(tick) && $past(cnt) == $past(len_low) - PH_W'(1)));

   // R9: idle without a request stays idle
   a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_IDLE && !run) |=> (st == PH_IDLE));

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int CNT_W       = 5,
   parameter int SEL_W       = 3,
   parameter int SEL_LSB     = 4,
   parameter int KEY_BIT     = 3,
   parameter int OVH_DIRECT  = 4,
   parameter int OVH_DIV     = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit FILTER_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              run,
   input  logic              scl_in,
   output logic              scl_drive_low,
   output logic              strobe_change,
   output logic              strobe_sample
);

   logic [SEL_W-1:0] sel;
   logic [CNT_W-1:0] low_cnt, high_cnt;
   logic             tick, count_en, scl_seen;

   scl_cfg_regs #(
      .DATA_W (DATA_W), .ADDR_W (ADDR_W), .CNT_W (CNT_W),
      .SEL_W (SEL_W), .SEL_LSB (SEL_LSB), .KEY_BIT (KEY_BIT)
   ) u_regs (
      .clk (clk), .rst_n (rst_n), .wr_en (cfg_wr), .addr (cfg_addr),
      .wdata (cfg_wdata), .rdata (cfg_rdata), .sel (sel),
      .low_cnt (low_cnt), .high_cnt (high_cnt)
   );

   scl_prescaler #(.SEL_W (SEL_W)) u_presc (
      .clk (clk), .rst_n (rst_n), .en (count_en), .sel (sel), .tick (tick)
   );

   scl_in_filter #(.SYNC_STAGES (SYNC_STAGES), .FILTER_EN (FILTER_EN)) u_filt (
      .clk (clk), .rst_n (rst_n), .scl_in (scl_in), .scl_seen (scl_seen)
   );

   scl_phase_fsm #(
      .CNT_W (CNT_W), .SEL_W (SEL_W),
      .OVH_DIRECT (OVH_DIRECT), .OVH_DIV (OVH_DIV)
   ) u_fsm (
      .clk (clk), .rst_n (rst_n), .run (run), .tick (tick),
      .scl_seen (scl_seen), .sel (sel), .low_cnt (low_cnt),
      .high_cnt (high_cnt), .count_en (count_en), .drive_low (scl_drive_low),
      .strobe_change (strobe_change), .strobe_sample (strobe_sample)
   );

endmodule

// File: tb/sim_scl_clock_gen.sv
module sim_scl_clock_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [1:0] cfg_addr = 2'd0;
   logic [7:0] cfg_wdata = 8'd0;
   logic [7:0] cfg_rdata;
   logic       run = 1'b0;
   logic       hold = 1'b0;
   logic       scl_bus;
   logic       scl_drive_low, strobe_change, strobe_sample;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   assign scl_bus = !(scl_drive_low || hold);

   scl_clock_gen u0 (
      .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_addr (cfg_addr),
      .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata), .run (run),
      .scl_in (scl_bus), .scl_drive_low (scl_drive_low),
      .strobe_change (strobe_change), .strobe_sample (strobe_sample)
   );

   function automatic int ovh(input int sel);
      return (sel == 0) ? 4 : 3;
   endfunction

   function automatic int exp_low(input int sel, input int lo);
      return (lo + ovh(sel)) << sel;
   endfunction

   function automatic int exp_rel(input int sel, input int hi, input int d);
      return 5 + d + ((hi + ovh(sel)) << sel);
   endfunction

   function automatic int exp_samp(input int sel, input int hi, input int d);
      return 6 + d + (((hi + ovh(sel)) / 2) << sel);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = 2'(a); cfg_wdata = 8'(d);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd_chk(input int a, input int exp, input string req);
      @(negedge clk);
      cfg_addr = 2'(a);
      #1;
      chk(cfg_rdata == 8'(exp), req, int'(cfg_rdata), exp);
   endtask

   // two phases: the first is measured fully, run drops in the second
   task automatic run_case(input int sel, input int lo, input int hi, input int d);
      int lc, rc, s_at, s_n, bad, lim;
      wr(0, (sel << 4) | 8);
      wr(1, lo);
      wr(2, hi);
      @(negedge clk);
      run = 1'b1;
      hold = (d > 0);
      @(negedge clk);
      chk(scl_drive_low == 1'b1, "R9 low starts one edge after run", int'(scl_drive_low), 1);
      for (int ph = 0; ph < 2; ph++) begin
         hold = (d > 0);
         lc = 0; bad = 0;
         while (scl_drive_low && lc < 20000) begin
            if (strobe_change != (lc == 0)) bad++;
            if (strobe_sample) bad++;
            if (ph == 1 && lc == 0) run = 1'b0;
            lc++;
            @(negedge clk);
         end
         chk(lc == exp_low(sel, lo), "R4 low phase width", lc, exp_low(sel, lo));
         chk(bad == 0, "R7 change strobe only in first low cycle", bad, 0);
         rc = 0; s_at = 0; s_n = 0; bad = 0;
         lim = (ph == 0) ? 20000 : exp_rel(sel, hi, d) + 40;
         while (rc < lim && (ph == 1 || !scl_drive_low)) begin
            rc++;
            if (rc > d) hold = 1'b0;
            if (strobe_sample) begin s_n++; s_at = rc; end
            if (strobe_change) bad++;
            if (ph == 1 && scl_drive_low) bad++;
            @(negedge clk);
         end
         if (ph == 0) begin
            if (d == 0)
               chk(rc == exp_rel(sel, hi, d), "R5 released width", rc, exp_rel(sel, hi, d));
            else
               chk(rc == exp_rel(sel, hi, d), "R6 stretched released width", rc, exp_rel(sel, hi, d));
            chk(bad == 0, "R7 no change strobe while released", bad, 0);
         end else begin
            chk(bad == 0, "R10 no new low phase after run drop", bad, 0);
         end
         chk(s_n == 1, "R8 one sample strobe per high phase", s_n, 1);
         chk(s_at == exp_samp(sel, hi, d), "R8 sample strobe position", s_at, exp_samp(sel, hi, d));
      end
      chk(scl_drive_low == 1'b0, "R10 line released at end", int'(scl_drive_low), 0);
      hold = 1'b0;
   endtask

   initial begin
      int bad;
      void'($urandom(32'h5C1A7));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values and reserved bits
      rd_chk(0, 8'h8F, "R1 reset prescale reg");
      rd_chk(1, 8'hFF, "R1 reset low count reg");
      rd_chk(2, 8'hFF, "R1 reset high count reg");
      rd_chk(3, 8'hFF, "R1 unused address");

      // R9: idle is quiet
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (scl_drive_low || strobe_change || strobe_sample) bad++;
      end
      chk(bad == 0, "R9 idle released and quiet", bad, 0);

      // R2: key bit guards the select
      wr(0, 8'h58);
      rd_chk(0, 8'hDF, "R2 keyed select write");
      wr(0, 8'h30);
      rd_chk(0, 8'hDF, "R2 unkeyed write ignored");

      // R3: zero floors to one, reserved write bits ignored
      wr(1, 8'h00);
      rd_chk(1, 8'hE1, "R3 low count zero stored as one");
      wr(2, 8'h00);
      rd_chk(2, 8'hE1, "R3 high count zero stored as one");
      wr(1, 8'h05);
      rd_chk(1, 8'hE5, "R3 reserved bits read one");

      // directed corners
      run_case(0, 1, 1, 0);
      run_case(0, 31, 31, 0);
      run_case(1, 1, 2, 3);
      run_case(7, 31, 31, 0);
      run_case(2, 7, 4, 12);

      // constrained random
      for (int i = 0; i < 10; i++) begin
         run_case(int'($urandom_range(3, 0)), int'($urandom_range(31, 1)),
                  int'($urandom_range(31, 1)), int'($urandom_range(9, 0)));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule